// File: doc/BRIEF.md
# Eight-Lane Broadcast Multiply-Accumulate Array

This block computes one forward step of a neural-network layer on eight output units at once. A 128-bit beat stream feeds it. The first beat of a pass carries a vector of eight signed 8-bit activations in its low 64 bits, and the array stores them. Each of the next eight beats carries eight signed 16-bit weights, one per lane. Weight beat k is multiplied by stored activation k, which is broadcast to every lane. Each lane adds its own product into a private 32-bit accumulator. The accumulator saturates at the 32-bit signed bounds instead of wrapping.

Passes can be chained, so one output group can cover more than eight inputs. The first beat of a pass carries three side inputs. A clear flag zeroes the accumulators before the pass. A last flag marks the pass that ends the group. A 2-bit clip code selects how the results are presented. After the final weight beat of a last pass, the array presents all eight accumulators for one cycle. Each result is clipped by a saturating limiter to 8, 16 or 24 bits, or passed through at 32 bits. During that cycle the array refuses new beats. Each lane also keeps a sticky flag that records whether its accumulator has ever saturated.

Top module: `vecmac_array`

## Requirements
- R1: After a synchronous active-low reset, `beat_ready` is 1, `res_valid` is 0 and every bit of `lane_ovf` is 0.
- R2: The first accepted beat of a pass stores eight signed 8-bit activations. Activation k is taken from `beat_data[8k+7:8k]`. Bits 127:64 of that beat have no effect on any result.
- R3: Accepted weight beat k (k = 0..7, the k-th beat after the activation beat) adds, in lane i, the signed product of `beat_data[16i+15:16i]` and activation k. Both operands are sign-extended to 32 bits before the add.
- R4: When `pass_clear` is 1 on the activation beat, every accumulator restarts from zero for that pass. When it is 0, the pass adds onto the previous sums.
- R5: The accumulator saturates. A sum above 2147483647 becomes 2147483647, and a sum below -2147483648 becomes -2147483648.
- R6: Bit i of `lane_ovf` goes to 1 in the cycle after lane i saturates. It stays 1 until an activation beat with `pass_clear` = 1, or a reset, brings it back to 0.
- R7: On presentation, each 32-bit lane result is clipped to the signed range selected by `clip_sel`, which is sampled on the activation beat: 00 selects 8 bits, 01 selects 16 bits, 10 selects 24 bits and 11 selects the unchanged 32-bit value. The clipped result is sign-extended into its 32-bit slot of `res_data`, with lane i in bits 32i+31:32i.
- R8: `res_valid` is high for exactly one cycle, the cycle after the ninth beat of a pass whose activation beat had `pass_last` = 1. It never rises for other passes, and `beat_ready` is low exactly in that cycle.
- R9: A beat is consumed only when `beat_valid` and `beat_ready` are both high. Idle cycles and beats held while ready is low change neither the beat order nor the sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| beat_valid | input | 1 | Beat offered on `beat_data` |
| beat_ready | output | 1 | Array can take a beat this cycle |
| beat_data | input | 128 | Activation vector (low 64 bits) or eight weights |
| pass_clear | input | 1 | Zero accumulators and flags; sampled on the activation beat |
| pass_last | input | 1 | This pass ends the output group; sampled on the activation beat |
| clip_sel | input | 2 | Result clip code; sampled on the activation beat |
| res_valid | output | 1 | Clipped results are on `res_data` |
| res_data | output | 256 | Eight clipped 32-bit lane results |
| lane_ovf | output | 8 | Sticky per-lane saturation flags |

## Verification
Two things can happen on the same beat: an accumulator can saturate, and that same beat can be the final weight beat of a last pass, so it also starts result presentation. The bench provokes this with 64 chained passes in which each lane's product is exactly +2^22. The even lanes therefore cross 2^31 on the closing beat of the 64th pass. In the following cycle the bench expects `res_valid`, the saturated value 2147483647 and the newly set overflow flag all together. The odd lanes carry a product of the opposite sign. They saturate only on a later pass, so the bench also confirms that a lane which has not saturated keeps its flag clear in the same result cycle.

// File: rtl/vmac_pkg.sv
// Package: shared clip-code type and limiter widths for the MAC array.
// Assumes: clip codes are fixed by the block's interface definition.
package vmac_pkg;
    typedef enum logic [1:0] {
        CLIP_8    = 2'b00,
        CLIP_16   = 2'b01,
        CLIP_24   = 2'b10,
        CLIP_NONE = 2'b11
    } clip_e;

    localparam int CLIP_W_SMALL = 8;
    localparam int CLIP_W_MID   = 16;
    localparam int CLIP_W_WIDE  = 24;
endpackage

// File: rtl/vmac_seq.sv
// Module: vmac_seq
// Counts the beats of a pass (one activation beat, then LANES weight beats).
// It produces the load, accumulate and clear strobes and the broadcast index,
// and raises a one-cycle result strobe after the last pass of a group.
// Assumes: LANES >= 2. Side inputs are meaningful only on the activation beat.
module vmac_seq #(
    parameter int LANES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       beat_valid,
    input  logic                       pass_clear,
    input  logic                       pass_last,
    input  logic [1:0]                 clip_sel,
    output logic                       beat_ready,
    output logic                       load_x,
    output logic                       mac_en,
    output logic                       clear_acc,
    output logic [$clog2(LANES)-1:0]   x_idx,
    output logic                       res_valid,
    output logic [1:0]                 clip_q
);
    localparam int CW = $clog2(LANES + 1);
    localparam int IW = $clog2(LANES);

    logic [CW-1:0] cnt_q;
    logic          last_q;
    logic          pres_q;
    logic          accept;

    // Handshake and strobe decode for the current beat.
    always_comb begin
        beat_ready = !pres_q;
        accept     = beat_valid && !pres_q;
        load_x     = accept && (cnt_q == '0);
        clear_acc  = load_x && pass_clear;
        mac_en     = accept && (cnt_q != '0);
        x_idx      = IW'(cnt_q - CW'(1));
        res_valid  = pres_q;
    end

    // Beat counter, pass side-input capture and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= 1'b0;
            pres_q <= 1'b0;
            clip_q <= 2'b00;
        end else begin
            pres_q <= accept && (cnt_q == CW'(LANES)) && last_q;
            if (accept) begin
                if (cnt_q == '0) begin
                    cnt_q  <= CW'(1);
                    last_q <= pass_last;
                    clip_q <= clip_sel;
                end else if (cnt_q == CW'(LANES)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    // R8: result strobe lasts a single cycle
    p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9: no beat is consumed while results are presented
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(load_x || mac_en));

    // R3: beat counter stays within one pass
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LANES));
endmodule

// File: rtl/vmac_lane.sv
// Module: vmac_lane
// One lane: multiplies a signed activation by a signed weight and adds the
// sign-extended product into a saturating accumulator. A sticky flag records
// any saturation.
// Assumes: ACC_W > X_W + W_W. clear and mac_en are never high together.
module vmac_lane #(
    parameter int X_W   = 8,
    parameter int W_W   = 16,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    mac_en,
    input  logic signed [X_W-1:0]   x,
    input  logic signed [W_W-1:0]   w,
    output logic signed [ACC_W-1:0] acc,
    output logic                    ovf
);
    localparam int PW = X_W + W_W;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [PW-1:0]  prod;
    logic signed [ACC_W:0] sum;
    logic signed [ACC_W-1:0] sat_sum;
    logic                  sat_hit;

    // Product, widened sum and saturation decision.
    always_comb begin
        prod    = x * w;
        sum     = {acc[ACC_W-1], acc} + {{(ACC_W+1-PW){prod[PW-1]}}, prod};
        sat_hit = sum[ACC_W] != sum[ACC_W-1];
        if (!sat_hit)
            sat_sum = sum[ACC_W-1:0];
        else if (sum[ACC_W])
            sat_sum = ACC_MIN;
        else
            sat_sum = ACC_MAX;
    end

    // Accumulator and sticky overflow update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (clear) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (mac_en) begin
            acc <= sat_sum;
            ovf <= ovf | sat_hit;
        end
    end

    // R5: a full accumulator stays full under a non-negative product
    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && acc == ACC_MAX && !prod[PW-1]) |=> acc == ACC_MAX);

    // R6: overflow flag only drops on clear
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clear) |=> ovf);

    // R3: accumulator holds when no weight beat is consumed
    p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_en && !clear) |=> $stable(acc));
endmodule

// File: rtl/vmac_clip.sv
// Module: vmac_clip
// Saturating limiter. It clips a signed word to 8, 16 or 24 bits by code, or
// passes it through, and keeps the result sign-extended in the full width.
// Assumes: ACC_W > 24.
module vmac_clip
    import vmac_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic [1:0]              sel,
    input  logic signed [ACC_W-1:0] din,
    output logic signed [ACC_W-1:0] dout
);
    localparam logic signed [ACC_W-1:0] HI8  = (ACC_W'(1) <<< (CLIP_W_SMALL-1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] HI16 = (ACC_W'(1) <<< (CLIP_W_MID-1))   - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] HI24 = (ACC_W'(1) <<< (CLIP_W_WIDE-1))  - ACC_W'(1);

    logic signed [ACC_W-1:0] hi;
    logic signed [ACC_W-1:0] lo;

    // Pick bounds from the code and clamp.
    always_comb begin
        case (clip_e'(sel))
            CLIP_8:  hi = HI8;
            CLIP_16: hi = HI16;
            CLIP_24: hi = HI24;
            default: hi = {1'b0, {(ACC_W-1){1'b1}}};
        endcase
        lo = -hi - ACC_W'(1);
        if (din > hi)
            dout = hi;
        else if (din < lo)
            dout = lo;
        else
            dout = din;
    end
endmodule

// File: rtl/vecmac_array.sv
// Module: vecmac_array (top)
// Eight-lane broadcast multiply-accumulate array for one layer step.
// It stores an activation vector and broadcasts activation k to all lanes
// for weight beat k. Lane sums are presented through saturating limiters.
// Assumes: BUS_W == LANES*W_W and LANES*X_W <= BUS_W.
module vecmac_array
    import vmac_pkg::*;
#(
    parameter int LANES = 8,
    parameter int X_W   = 8,
    parameter int W_W   = 16,
    parameter int ACC_W = 32,
    parameter int BUS_W = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   beat_valid,
    output logic                   beat_ready,
    input  logic [BUS_W-1:0]       beat_data,
    input  logic                   pass_clear,
    input  logic                   pass_last,
    input  logic [1:0]             clip_sel,
    output logic                   res_valid,
    output logic [LANES*ACC_W-1:0] res_data,
    output logic [LANES-1:0]       lane_ovf
);
    localparam int IW = $clog2(LANES);

    logic          load_x;
    logic          mac_en;
    logic          clear_acc;
    logic [IW-1:0] x_idx;
    logic [1:0]    clip_q;
    logic signed [X_W-1:0] x_q [LANES];
    logic signed [X_W-1:0] x_bcast;

    vmac_seq #(.LANES(LANES)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .pass_clear (pass_clear),
        .pass_last  (pass_last),
        .clip_sel   (clip_sel),
        .beat_ready (beat_ready),
        .load_x     (load_x),
        .mac_en     (mac_en),
        .clear_acc  (clear_acc),
        .x_idx      (x_idx),
        .res_valid  (res_valid),
        .clip_q     (clip_q)
    );

    // Broadcast mux: activation selected by the weight-beat index.
    always_comb x_bcast = x_q[x_idx];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] clipped;

        // Activation store for element g, written on the activation beat.
        always_ff @(posedge clk) begin
            if (!rst_n)
                x_q[g] <= '0;
            else if (load_x)
                x_q[g] <= beat_data[g*X_W +: X_W];
        end

        vmac_lane #(.X_W(X_W), .W_W(W_W), .ACC_W(ACC_W)) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear_acc),
            .mac_en (mac_en),
            .x      (x_bcast),
            .w      (beat_data[g*W_W +: W_W]),
            .acc    (acc),
            .ovf    (lane_ovf[g])
        );

        vmac_clip #(.ACC_W(ACC_W)) clip_i (
            .sel  (clip_q),
            .din  (acc),
            .dout (clipped)
        );

        assign res_data[g*ACC_W +: ACC_W] = clipped;

        // R7: 8-bit clip code keeps presented values in the 8-bit range
        p_clip8_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && clip_q == CLIP_8) |->
            (clipped <= ACC_W'(127) && clipped >= -ACC_W'(128)));
    end
endmodule

// File: tb/vecmac_array_tb_top.sv
`timescale 1ns/1ps
module vecmac_array_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         beat_valid;
    logic         beat_ready;
    logic [127:0] beat_data;
    logic         pass_clear;
    logic         pass_last;
    logic [1:0]   clip_sel;
    logic         res_valid;
    logic [255:0] res_data;
    logic [7:0]   lane_ovf;

    always #4 clk = ~clk;

    vecmac_array dut_i (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_data(beat_data), .pass_clear(pass_clear), .pass_last(pass_last),
        .clip_sel(clip_sel), .res_valid(res_valid), .res_data(res_data),
        .lane_ovf(lane_ovf)
    );

    int total = 0;
    int bad   = 0;
    string cur_tag = "R1";

    // behavioural reference state
    int      m_cnt;
    bit      m_pres;
    longint  m_x   [N];
    longint  m_acc [N];
    bit      m_ovf [N];
    bit      m_last;
    logic [1:0] m_sel;
    logic [127:0] wbuf [N];

    localparam longint AMAX = 64'sd2147483647;
    localparam longint AMIN = -64'sd2147483648;

    function automatic longint clip_ref(longint v, logic [1:0] s);
        int w;
        longint hi, lo;
        w  = (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : (s == 2'b10) ? 24 : 32;
        hi = (64'sd1 <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(beat_ready == !m_pres, "R8", "beat_ready", beat_ready, !m_pres);
        chk(res_valid == m_pres, "R8", "res_valid", res_valid, m_pres);
        for (int i = 0; i < N; i++)
            chk(lane_ovf[i] == m_ovf[i], "R6", $sformatf("lane_ovf[%0d]", i),
                lane_ovf[i], m_ovf[i]);
        if (m_pres)
            for (int i = 0; i < N; i++) begin
                longint a = longint'($signed(res_data[32*i +: 32]));
                longint e = clip_ref(m_acc[i], m_sel);
                chk(a == e, cur_tag, $sformatf("lane %0d result", i), a, e);
            end
    endtask

    // Advance one clock: update the model from the driven inputs, then compare.
    task automatic tick();
        bit acc_ok;
        bit nxt_pres;
        acc_ok   = beat_valid && !m_pres;
        nxt_pres = 1'b0;
        if (!rst_n) begin
            m_cnt = 0; m_last = 0; m_sel = 2'b00;
            for (int i = 0; i < N; i++) begin m_x[i] = 0; m_acc[i] = 0; m_ovf[i] = 0; end
        end else if (acc_ok) begin
            if (m_cnt == 0) begin
                for (int i = 0; i < N; i++) m_x[i] = longint'($signed(beat_data[8*i +: 8]));
                if (pass_clear)
                    for (int i = 0; i < N; i++) begin m_acc[i] = 0; m_ovf[i] = 0; end
                m_last = pass_last;
                m_sel  = clip_sel;
                m_cnt  = 1;
            end else begin
                for (int i = 0; i < N; i++) begin
                    longint s = m_acc[i] + m_x[m_cnt-1] * longint'($signed(beat_data[16*i +: 16]));
                    if (s > AMAX) begin s = AMAX; m_ovf[i] = 1; end
                    if (s < AMIN) begin s = AMIN; m_ovf[i] = 1; end
                    m_acc[i] = s;
                end
                if (m_cnt == N) begin
                    m_cnt = 0;
                    nxt_pres = m_last;
                end else m_cnt++;
            end
        end
        if (rst_n) m_pres = nxt_pres; else m_pres = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    // Offer one beat and hold it until consumed.
    task automatic send(logic [127:0] d, bit clr, bit last, logic [1:0] sel);
        bit took;
        beat_data  = d;
        pass_clear = clr;
        pass_last  = last;
        clip_sel   = sel;
        beat_valid = 1'b1;
        do begin
            took = !m_pres;
            tick();
        end while (!took);
    endtask

    // One pass: activation beat (with upper filler) then the eight weights in wbuf.
    task automatic do_pass(logic [63:0] xv, logic [63:0] upper, bit clr, bit last,
                           logic [1:0] sel, bit gaps);
        send({upper, xv}, clr, last, sel);
        for (int k = 0; k < N; k++) begin
            if (gaps) begin
                beat_valid = 1'b0;
                beat_data  = {4{$urandom}};
                tick();
            end
            send(wbuf[k], $urandom_range(0, 1), $urandom_range(0, 1), 2'($urandom));
        end
        beat_valid = 1'b0;
    endtask

    task automatic rand_weights();
        for (int k = 0; k < N; k++) wbuf[k] = {$urandom, $urandom, $urandom, $urandom};
    endtask

    // Idle cycles so a presented result is compared.
    task automatic idle(int n);
        beat_valid = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; beat_valid = 1'b0; beat_data = '0;
        pass_clear = 1'b0; pass_last = 1'b0; clip_sel = 2'b00;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state at the ports
        chk(beat_ready == 1'b1, "R1", "beat_ready after reset", beat_ready, 1);
        chk(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        chk(lane_ovf == 8'h00, "R1", "lane_ovf after reset", lane_ovf, 0);

        // R2: upper half of the activation beat must not matter
        cur_tag = "R2";
        rand_weights();
        do_pass({$urandom, $urandom}, 64'hDEAD_BEEF_F00D_CAFE, 1, 1, 2'b11, 0);
        idle(2);

        // R3: single passes with random operands, full-width output
        cur_tag = "R3";
        for (int t = 0; t < 4; t++) begin
            rand_weights();
            do_pass({$urandom, $urandom}, {$urandom, $urandom}, 1, 1, 2'b11, 0);
            idle(1);
        end

        // R4: chained passes without clear, then a clear restarts the sums
        cur_tag = "R4";
        for (int p = 0; p < 3; p++) begin
            rand_weights();
            do_pass({$urandom, $urandom}, '0, p == 0, p == 2, 2'b11, 0);
        end
        idle(1);
        rand_weights();
        do_pass({$urandom, $urandom}, '0, 1, 1, 2'b11, 0);
        idle(1);

        // R5/R6: even lanes +2^22 per product, odd lanes -4194176 per product.
        // Even lanes hit the ceiling on the final beat of pass 64, which is
        // also the beat that launches result presentation.
        cur_tag = "R5";
        for (int k = 0; k < N; k++)
            for (int i = 0; i < N; i++)
                wbuf[k][16*i +: 16] = (i % 2 == 0) ? 16'h8000 : 16'h7FFF;
        for (int p = 0; p < 64; p++)
            do_pass(64'h8080_8080_8080_8080, '0, p == 0, p == 63, 2'b11, 0);
        idle(1);
        chk(lane_ovf == 8'h55, "R6", "even lanes saturated, odd clear", lane_ovf, 8'h55);
        for (int p = 0; p < 2; p++)
            do_pass(64'h8080_8080_8080_8080, '0, 0, p == 1, 2'b11, 0);
        idle(1);
        chk(lane_ovf == 8'hFF, "R5", "odd lanes reach the floor", lane_ovf, 8'hFF);

        // R6: flags stay set across a pass without clear, drop on clear
        cur_tag = "R6";
        rand_weights();
        do_pass(64'h0102_0304_0506_0708, '0, 0, 1, 2'b00, 0);
        idle(1);
        chk(lane_ovf == 8'hFF, "R6", "flags sticky", lane_ovf, 8'hFF);
        rand_weights();
        do_pass(64'h0102_0304_0506_0708, '0, 1, 1, 2'b10, 0);
        idle(1);
        chk(lane_ovf == 8'h00, "R6", "flags cleared", lane_ovf, 8'h00);

        // R7: each clip code on large sums
        cur_tag = "R7";
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 2; t++) begin
                rand_weights();
                do_pass({$urandom, $urandom}, '0, 1, 1, 2'(s), 0);
                idle(1);
            end
        end

        // R8/R9: idle gaps between beats, and a pass offered during presentation
        cur_tag = "R9";
        rand_weights();
        do_pass({$urandom, $urandom}, '0, 1, 1, 2'b01, 1);
        rand_weights();
        do_pass({$urandom, $urandom}, '0, 1, 0, 2'b01, 1);
        rand_weights();
        do_pass({$urandom, $urandom}, '0, 0, 1, 2'b10, 0);
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule